// File: doc/BRIEF.md
# Pipelined Adder-Subtractor with Carry and Overflow Flags

This block adds or subtracts two operands of a configurable width and returns the sum, the carry out of the top bit and an overflow flag. A parameter picks two's complement or unsigned interpretation of the operands, and that choice decides what the overflow flag means. A second parameter either lets an input pin choose add or subtract on every cycle, or fixes the operation at elaboration time. When the operation is fixed, that pin is ignored.

Subtraction treats the carry input as an active-high "no borrow" bit, so the block computes A - B + cin - 1. Driving cin high therefore gives a plain difference. This lets several instances be chained into a wider subtractor.

A latency parameter places a number of register stages after the arithmetic. Sum, carry and overflow travel through the same stages, so they always stay aligned. A latency of zero makes the whole block combinational. The stages clear to zero asynchronously and freeze while the clock enable is low.

Top module: `pipe_addsub`

## Requirements
- R1: When the operation is add, the sum output equals (op_a + op_b + cin) modulo 2^WIDTH, and cout_o is 1 exactly when that total reaches 2^WIDTH or more.
- R2: When the operation is subtract, the sum output equals (op_a - op_b + cin - 1) modulo 2^WIDTH, and cout_o is 1 exactly when that difference, taken as an integer, is zero or positive (no borrow).
- R3: With IS_SIGNED=1, ovf_o is 1 exactly when the true two's complement result of the selected operation falls outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R4: With IS_SIGNED=0, ovf_o equals cout_o for add and the inverse of cout_o for subtract.
- R5: OP_MODE encoding: 0 means add_sel chooses the operation (1 = add, 0 = subtract), 1 forces add and 2 forces subtract. In modes 1 and 2, add_sel has no effect on any output.
- R6: Every output shows the result for the inputs sampled LATENCY enabled clock edges earlier, and all three outputs stay aligned. With LATENCY=0, the outputs follow the inputs with no clock involved.
- R7: While clr is high, every output is 0, and this takes effect at once, without waiting for a clock edge.
- R8: While ce is low, the outputs and all stages in flight hold their values. Data is neither lost nor advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register stages |
| clr | input | 1 | Asynchronous clear of all stages, active high |
| ce | input | 1 | Clock enable of the stages, active high |
| cin | input | 1 | Carry-in; acts as an inverted borrow when subtracting |
| add_sel | input | 1 | 1 = add, 0 = subtract (used only when OP_MODE is 0) |
| op_a | input | WIDTH | First operand (augend or minuend) |
| op_b | input | WIDTH | Second operand (addend or subtrahend) |
| sum_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the most significant bit |
| ovf_o | output | 1 | Overflow for the selected representation |

## Verification
A corrupted stage register shows up at the ports exactly LATENCY enabled edges after the item that entered it. A stage that shifts while ce is low shows up in the cycles that follow. In both cases the scoreboard sees the mismatch at the first output the fault reaches. A flag bug appears only for particular operands. For that reason the operand pairs sweep the sign boundaries and the all-ones and all-zeros values, with both carry-in levels and both operations. Any error in the combinational flag logic is visible at once in the zero-latency instances.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_FROM_PORT = 2'd0,
    OP_FORCE_ADD = 2'd1,
    OP_FORCE_SUB = 2'd2
  } op_mode_e;
endpackage

// File: rtl/addsub_dir.sv
module addsub_dir #(
  parameter addsub_pkg::op_mode_e OP_MODE = addsub_pkg::OP_FROM_PORT
) (
  input  logic add_sel,
  output logic do_sub
);
  // R5: a fixed mode ignores the select pin
  generate
    if (OP_MODE == addsub_pkg::OP_FORCE_ADD) begin : g_add
      logic unused_sel;
      assign unused_sel = add_sel;
      assign do_sub = 1'b0;
    end else if (OP_MODE == addsub_pkg::OP_FORCE_SUB) begin : g_sub
      logic unused_sel;
      assign unused_sel = add_sel;
      assign do_sub = 1'b1;
    end else begin : g_port
      assign do_sub = ~add_sel;
    end
  endgenerate
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH     = 8,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             do_sub,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   total;
  logic             carry_into_msb;

  // Subtract as a + ~b + cin, which equals a - b + cin - 1
  assign b_eff          = do_sub ? ~b : b;
  assign total          = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign res            = total[MSB:0];
  assign cout           = total[WIDTH];
  assign carry_into_msb = a[MSB] ^ b_eff[MSB] ^ total[MSB];

  generate
    if (IS_SIGNED) begin : g_signed
      assign ovf = carry_into_msb ^ cout;
    end else begin : g_unsigned
      assign ovf = do_sub ? ~cout : cout;
    end
  endgenerate

  always_comb begin
    // R3: signed overflow always flips the sign relative to a
    if (IS_SIGNED && ovf)
      assert_ovf_sign_flip_R3: assert (res[MSB] != a[MSB]);
    // R3: operands pulling in opposite directions can never overflow
    if (IS_SIGNED && ((a[MSB] != b[MSB]) != do_sub))
      assert_no_overflow_R3: assert (!ovf);
    // R4: an unsigned add that wraps lands at or below a
    if (!IS_SIGNED && !do_sub && ovf)
      assert_add_wrap_R4: assert (res <= a);
    // R4: an unsigned borrow lands at or above a
    if (!IS_SIGNED && do_sub && ovf)
      assert_sub_wrap_R4: assert (res >= a);
    // R2: equal operands with cin high give zero and no borrow
    if (do_sub && cin && (a == b))
      assert_equal_diff_R2: assert (res == '0 && cout);
  end
endmodule

// File: rtl/addsub_pipe.sv
module addsub_pipe #(
  parameter int DW      = 10,
  parameter int LATENCY = 3
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          ce,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  generate
    if (LATENCY == 0) begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ clr ^ ce;
      assign dout = din;
    end else begin : g_regs
      logic [DW-1:0] stg [LATENCY];

      always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
          for (int i = 0; i < LATENCY; i++) stg[i] <= '0;
        end else if (ce) begin
          stg[0] <= din;
          for (int i = 1; i < LATENCY; i++) stg[i] <= stg[i-1];
        end
      end

      assign dout = stg[LATENCY-1];

      // R7: clear holds the outputs at zero
      assert_clear_zero_R7: assert property (@(posedge clk) clr |-> (dout == '0));
      // R8: a disabled edge moves nothing
      assert_hold_R8: assert property (@(posedge clk) disable iff (clr)
        !ce |=> $stable(dout));
    end
  endgenerate
endmodule

// File: rtl/pipe_addsub.sv
module pipe_addsub #(
  parameter int WIDTH     = 8,
  parameter int LATENCY   = 3,
  parameter bit IS_SIGNED = 1'b1,
  parameter addsub_pkg::op_mode_e OP_MODE = addsub_pkg::OP_FROM_PORT
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ce,
  input  logic             cin,
  input  logic             add_sel,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int PW = WIDTH + 2;

  logic             do_sub;
  logic [WIDTH-1:0] res_c;
  logic             cout_c;
  logic             ovf_c;
  logic [PW-1:0]    pipe_out;

  addsub_dir #(.OP_MODE(OP_MODE)) u_dir (
    .add_sel (add_sel),
    .do_sub  (do_sub)
  );

  addsub_core #(.WIDTH(WIDTH), .IS_SIGNED(IS_SIGNED)) u_core (
    .a      (op_a),
    .b      (op_b),
    .cin    (cin),
    .do_sub (do_sub),
    .res    (res_c),
    .cout   (cout_c),
    .ovf    (ovf_c)
  );

  // R6: flags ride the same stages as the sum
  addsub_pipe #(.DW(PW), .LATENCY(LATENCY)) u_pipe (
    .clk  (clk),
    .clr  (clr),
    .ce   (ce),
    .din  ({ovf_c, cout_c, res_c}),
    .dout (pipe_out)
  );

  assign {ovf_o, cout_o, sum_o} = pipe_out;
endmodule

// File: tb/sim_pipe_addsub.sv
module sim_pipe_addsub;
  localparam int W   = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic ce  = 1'b1;
  logic cin = 1'b0;
  logic add_sel = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;

  logic [W-1:0] s0, s1, s2;
  logic c0, c1, c2, v0, v1, v2;

  int errors = 0;
  int checks = 0;
  int tick   = 0;
  bit done   = 0;

  typedef struct {
    logic [W+1:0] exp;
    int           due;
    string        tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  pipe_addsub #(.WIDTH(W), .LATENCY(LAT), .IS_SIGNED(1'b1),
                .OP_MODE(addsub_pkg::OP_FROM_PORT)) u0 (
    .clk(clk), .clr(clr), .ce(ce), .cin(cin), .add_sel(add_sel),
    .op_a(op_a), .op_b(op_b), .sum_o(s0), .cout_o(c0), .ovf_o(v0));

  pipe_addsub #(.WIDTH(W), .LATENCY(0), .IS_SIGNED(1'b0),
                .OP_MODE(addsub_pkg::OP_FORCE_SUB)) u1 (
    .clk(clk), .clr(clr), .ce(ce), .cin(cin), .add_sel(add_sel),
    .op_a(op_a), .op_b(op_b), .sum_o(s1), .cout_o(c1), .ovf_o(v1));

  pipe_addsub #(.WIDTH(W), .LATENCY(0), .IS_SIGNED(1'b0),
                .OP_MODE(addsub_pkg::OP_FORCE_ADD)) u2 (
    .clk(clk), .clr(clr), .ce(ce), .cin(cin), .add_sel(add_sel),
    .op_a(op_a), .op_b(op_b), .sum_o(s2), .cout_o(c2), .ovf_o(v2));

  // Reference: {ovf, cout, sum} from integer arithmetic
  function automatic logic [W+1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic c, logic sub, bit sgn);
    int ua, ub, full, sa, sb, ideal;
    logic cy, ov;
    logic [31:0] fv;
    ua = int'(a);
    ub = int'(b);
    full = sub ? ua - ub + int'(c) - 1 : ua + ub + int'(c);
    cy = sub ? (full >= 0) : (full >= (1 << W));
    sa = int'($signed(a));
    sb = int'($signed(b));
    ideal = sub ? sa - sb + int'(c) - 1 : sa + sb + int'(c);
    if (sgn) ov = (ideal > (1 << (W-1)) - 1) || (ideal < -(1 << (W-1)));
    else     ov = sub ? !cy : cy;
    fv = full;
    return {ov, cy, fv[W-1:0]};
  endfunction

  task automatic chk(string req, logic [W+1:0] act, logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one item per negedge; the zero-latency instances are checked at once
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic c, logic sel);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; cin = c; add_sel = sel;
    it.exp = model(a, b, c, !sel, 1'b1);
    it.due = tick + LAT;
    it.tag = sel ? "R1/R3/R6" : "R2/R3/R6";
    q.push_back(it);
    #1;
    chk("R2/R4/R5/R6 forced sub", {v1, c1, s1}, model(a, b, c, 1'b1, 1'b0));
    chk("R1/R4/R5 forced add",    {v2, c2, s2}, model(a, b, c, 1'b0, 1'b0));
  endtask

  // Monitor: count enabled edges, compare items that have come due
  always @(posedge clk) begin
    if (ce && !clr) tick++;
    #5;
    while (q.size() > 0 && q[0].due == tick) begin
      chk(q[0].tag, {v0, c0, s0}, q[0].exp);
      void'(q.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [W-1:0] corners [8];

  initial begin
    logic [W+1:0] held;
    corners[0] = 8'h00; corners[1] = 8'h01; corners[2] = 8'h7F; corners[3] = 8'h80;
    corners[4] = 8'h81; corners[5] = 8'hFE; corners[6] = 8'hFF; corners[7] = 8'h40;

    repeat (3) @(posedge clk);
    #5;
    chk("R7 reset state", {v0, c0, s0}, '0);
    @(negedge clk);
    clr = 1'b0;

    // Corner sweep, both operations and both carry-in levels
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        drive(corners[i], corners[j], 1'b0, 1'b1);
        drive(corners[i], corners[j], 1'b1, 1'b0);
        drive(corners[i], corners[j], 1'b1, 1'b1);
        drive(corners[i], corners[j], 1'b0, 1'b0);
      end

    // Random operands
    for (int k = 0; k < 300; k++)
      drive(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));

    // R8: pause with data in flight; inputs keep changing
    drive(8'h7F, 8'h01, 1'b0, 1'b1);
    drive(8'h80, 8'h01, 1'b1, 1'b0);
    @(negedge clk);
    ce = 1'b0;
    held = {v0, c0, s0};
    for (int k = 0; k < 4; k++) begin
      op_a = W'($urandom); op_b = W'($urandom); add_sel = 1'($urandom);
      @(negedge clk);
      chk("R8 hold while ce low", {v0, c0, s0}, held);
    end
    ce = 1'b1;
    drive(8'h05, 8'h03, 1'b1, 1'b0);
    drive(8'hFF, 8'hFF, 1'b1, 1'b1);
    repeat (LAT + 2) @(negedge clk);
    chk("R6/R8 queue drained", 10'(q.size()), 10'd0);

    // R7: clear mid-cycle with data in flight
    drive(8'h12, 8'h34, 1'b0, 1'b1);
    drive(8'h56, 8'h78, 1'b1, 1'b0);
    #5;
    clr = 1'b1;
    #1;
    chk("R7 asynchronous clear", {v0, c0, s0}, '0);
    q.delete();
    @(negedge clk);
    chk("R7 cleared across edge", {v0, c0, s0}, '0);
    clr = 1'b0;

    drive(8'h7F, 8'h7F, 1'b1, 1'b1);
    drive(8'h00, 8'h01, 1'b0, 1'b0);
    repeat (LAT + 2) @(negedge clk);
    chk("R6 final drain", 10'(q.size()), 10'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule